// File: doc/BRIEF.md
# Effective Address Sequencer

This block works out the effective address of an operand for a small 8-bit processor core, one addressing mode at a time. The decoder supplies a mode code, the address of the first operand byte, the two index registers and the branch condition, and pulses `start`. The sequencer then reads the operand bytes, and any pointer bytes, one per cycle through a simple read port whose data returns in the same cycle as the address. It ends with a one-cycle `done` pulse. With that pulse it presents the address, the operand length in bytes, a page-crossed flag for extra-cycle timing, and the branch penalty in cycles.

Page wrapping follows the classic 8-bit rules. Zero-page arithmetic never leaves page zero. Pointer fetches from page zero wrap inside it. The two-byte pointer of the indirect mode takes its high byte from the same page as its low byte. A parameter selects this quirk or a plain carrying increment.

Top module: `addr_resolver`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req`, `page_cross`, `ea`, `op_len` and `penalty` are all zero.
- R2: Mode codes 0 (implied), 1 (accumulator) and the unused codes 13 to 15 make no memory read. They give `done` one cycle after `start` with `ea` = 0, `op_len` = 0 and `penalty` = 0.
- R3: A mode needing N memory reads raises `mem_req` for exactly N cycles and pulses `done` on the (N+1)th rising edge, counting the edge that samples `start`. N is 0 for codes 0, 1, 2 and 13 to 15; 1 for codes 3 to 6; 2 for codes 7 to 9; 3 for codes 11 and 12; and 4 for code 10. `op_len` is 0 for codes 0, 1 and 13 to 15; 2 for codes 7 to 10; and 1 for all others.
- R4: Code 2 (immediate) gives `ea` = `pc_in`, the address of the operand byte itself.
- R5: Code 3 (zero page) gives `ea` = {0, b}, where b is the byte at `pc_in`. Codes 4 and 5 give {0, (b + X) mod 256} and {0, (b + Y) mod 256}, so the high byte is always zero.
- R6: Code 6 (relative) gives `ea` = `pc_in` + 1 plus the sign-extended byte at `pc_in`. `page_cross` is set when the high byte of that target differs from the high byte of `pc_in` + 1.
- R7: For code 6, `penalty` is 0 when `taken` is low, 1 when taken within the same page, and 2 when taken across a page. It is 0 for every other mode.
- R8: Code 7 (absolute) reads the low byte at `pc_in` and the high byte at `pc_in` + 1. Codes 8 and 9 add X or Y to that base and set `page_cross` when the high byte changes.
- R9: Code 10 (indirect) forms a pointer p from the two operand bytes. It reads the result's low byte at p and its high byte at {p[15:8], p[7:0] + 1 mod 256}, when the page-wrap variant is selected (the default).
- R10: Code 11 (indexed-indirect) reads the pointer bytes at (b + X) mod 256 and (b + X + 1) mod 256 in page zero.
- R11: Code 12 (indirect-indexed) reads the pointer bytes at b and (b + 1) mod 256 in page zero, adds Y, and sets `page_cross` when the high byte changes.
- R12: `page_cross` is cleared on the edge that accepts `start`. After `done`, `ea`, `page_cross`, `op_len` and `penalty` hold until the next accepted `start`.
- R13: `start` is ignored while `busy` is high; the computation under way completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation (accepted when not busy) |
| mode | input | 4 | Addressing mode code |
| pc_in | input | AW | Address of the first operand byte |
| x_in | input | DW | X index value |
| y_in | input | DW | Y index value |
| taken | input | 1 | Branch condition, used by relative mode |
| mem_req | output | 1 | Read request, one byte per cycle |
| mem_addr | output | AW | Read address |
| mem_rdata | input | DW | Read data, valid in the same cycle |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result pulse |
| ea | output | AW | Effective address |
| page_cross | output | 1 | Page boundary crossed |
| op_len | output | 2 | Operand length in bytes |
| penalty | output | 2 | Extra branch cycles |

## Verification
Every result is due on the (N+1)th rising edge after the edge that samples `start`, where N is the mode's read count. This puts zero-read modes one cycle after `start` and indirect mode five cycles after. The bench drives inputs just after the falling edge and counts edges until it sees `done` at a falling edge. That count must equal N+1, and the `mem_req` cycles seen before it must equal N. Only then are `ea`, `page_cross`, `op_len` and `penalty` compared with its own model. In the first cycle after an accepted `start` it also checks that `page_cross` is already clear. Two cycles after `done` it checks that the results are still held.

// File: rtl/addr_resolver_pkg.sv
package addr_resolver_pkg;

   localparam int MD_W = 4;

   typedef enum logic [MD_W-1:0] {
      MD_IMPL = 4'd0,
      MD_ACCU = 4'd1,
      MD_IMM  = 4'd2,
      MD_ZPG  = 4'd3,
      MD_ZPX  = 4'd4,
      MD_ZPY  = 4'd5,
      MD_REL  = 4'd6,
      MD_ABS  = 4'd7,
      MD_ABX  = 4'd8,
      MD_ABY  = 4'd9,
      MD_IND  = 4'd10,
      MD_IDX  = 4'd11,
      MD_IDY  = 4'd12
   } md_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPL,
      ST_OPH,
      ST_PTL,
      ST_PTH
   } st_e;

   // unused codes behave as implied
   function automatic md_e md_norm(input logic [MD_W-1:0] m);
      if (m > 4'd12) return MD_IMPL;
      return md_e'(m);
   endfunction

   function automatic logic [1:0] md_len(input md_e m);
      case (m)
         MD_IMPL, MD_ACCU:               return 2'd0;
         MD_ABS, MD_ABX, MD_ABY, MD_IND: return 2'd2;
         default:                        return 2'd1;
      endcase
   endfunction

   function automatic logic md_no_read(input md_e m);
      return (m == MD_IMPL) || (m == MD_ACCU) || (m == MD_IMM);
   endfunction

endpackage

// File: rtl/ar_index_add.sv
module ar_index_add #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic [AW-1:0] base,
   input  logic [DW-1:0] idx,
   output logic [AW-1:0] sum,
   output logic          crossed
);
   localparam int HW = AW - DW;

   assign sum     = base + {{HW{1'b0}}, idx};
   assign crossed = sum[AW-1:DW] != base[AW-1:DW];
endmodule

// File: rtl/ar_branch_calc.sv
module ar_branch_calc #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic [AW-1:0] pc_next,
   input  logic [DW-1:0] offset,
   input  logic          taken,
   output logic [AW-1:0] target,
   output logic          crossed,
   output logic [1:0]    penalty
);
   localparam int HW = AW - DW;

   assign target  = pc_next + {{HW{offset[DW-1]}}, offset};
   assign crossed = target[AW-1:DW] != pc_next[AW-1:DW];

   always_comb begin
      if (!taken)       penalty = 2'd0;
      else if (crossed) penalty = 2'd2;
      else              penalty = 2'd1;
   end
endmodule

// File: rtl/ar_ptr_step.sv
module ar_ptr_step #(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter bit PAGE_WRAP = 1'b1
) (
   input  logic [AW-1:0] ptr,
   output logic [AW-1:0] ptr_nxt
);
   generate
      if (PAGE_WRAP) begin : g_wrap
         logic [DW-1:0] lo_inc;
         assign lo_inc  = ptr[DW-1:0] + 1'b1;
         assign ptr_nxt = {ptr[AW-1:DW], lo_inc};
      end else begin : g_carry
         assign ptr_nxt = ptr + 1'b1;
      end
   endgenerate
endmodule

// File: rtl/addr_resolver.sv
module addr_resolver
   import addr_resolver_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter bit PAGE_WRAP = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [3:0]      mode,
   input  logic [AW-1:0]   pc_in,
   input  logic [DW-1:0]   x_in,
   input  logic [DW-1:0]   y_in,
   input  logic            taken,
   output logic            mem_req,
   output logic [AW-1:0]   mem_addr,
   input  logic [DW-1:0]   mem_rdata,
   output logic            busy,
   output logic            done,
   output logic [AW-1:0]   ea,
   output logic            page_cross,
   output logic [1:0]      op_len,
   output logic [1:0]      penalty
);
   localparam int HW = AW - DW;

   generate
      if (AW != 2 * DW) begin : g_bad_width
         $error("addr_resolver: AW must be twice DW");
      end
      if (DW < 2) begin : g_bad_dw
         $error("addr_resolver: DW too small");
      end
   endgenerate

   st_e           st_q, st_d;
   md_e           md_q, md_in;
   logic [AW-1:0] pc_q;
   logic [DW-1:0] x_q, y_q, b0_q, b1_q, pl_q;
   logic          tk_q;

   logic          ea_pc_q, done_q;
   logic [AW-1:0] ea_q;
   logic [1:0]    len_q, pen_q;

   logic          accept, fin;
   logic [AW-1:0] f_ea;
   logic          f_pc;
   logic [1:0]    f_pen;

   // ---- arithmetic helpers ----
   logic [DW-1:0] zp_x, zp_x1, zp_1;
   logic [AW-1:0] ind_ptr, ind_nxt;
   logic [AW-1:0] ix_base, ix_sum;
   logic [DW-1:0] ix_idx;
   logic          ix_cross;
   logic [AW-1:0] br_target;
   logic          br_cross;
   logic [1:0]    br_pen;

   assign md_in  = md_norm(mode);
   assign accept = start && (st_q == ST_IDLE);

   assign zp_x    = b0_q + x_q;
   assign zp_x1   = zp_x + 1'b1;
   assign zp_1    = b0_q + 1'b1;
   assign ind_ptr = {b1_q, b0_q};

   ar_ptr_step #(.AW(AW), .DW(DW), .PAGE_WRAP(PAGE_WRAP)) u_step (
      .ptr     (ind_ptr),
      .ptr_nxt (ind_nxt)
   );

   assign ix_base = (st_q == ST_PTH) ? {mem_rdata, pl_q} : {mem_rdata, b0_q};
   assign ix_idx  = (md_q == MD_ABY || md_q == MD_IDY) ? y_q : x_q;

   ar_index_add #(.AW(AW), .DW(DW)) u_index (
      .base    (ix_base),
      .idx     (ix_idx),
      .sum     (ix_sum),
      .crossed (ix_cross)
   );

   ar_branch_calc #(.AW(AW), .DW(DW)) u_branch (
      .pc_next (pc_q + 1'b1),
      .offset  (mem_rdata),
      .taken   (tk_q),
      .target  (br_target),
      .crossed (br_cross),
      .penalty (br_pen)
   );

   // ---- read port ----
   always_comb begin
      mem_addr = '0;
      case (st_q)
         ST_OPL: mem_addr = pc_q;
         ST_OPH: mem_addr = pc_q + 1'b1;
         ST_PTL: begin
            if (md_q == MD_IND)      mem_addr = ind_ptr;
            else if (md_q == MD_IDX) mem_addr = {{HW{1'b0}}, zp_x};
            else                     mem_addr = {{HW{1'b0}}, b0_q};
         end
         ST_PTH: begin
            if (md_q == MD_IND)      mem_addr = ind_nxt;
            else if (md_q == MD_IDX) mem_addr = {{HW{1'b0}}, zp_x1};
            else                     mem_addr = {{HW{1'b0}}, zp_1};
         end
         default: mem_addr = '0;
      endcase
   end

   assign mem_req = (st_q != ST_IDLE);

   // ---- sequencing and result selection ----
   always_comb begin
      st_d  = st_q;
      fin   = 1'b0;
      f_ea  = '0;
      f_pc  = 1'b0;
      f_pen = 2'd0;
      case (st_q)
         ST_IDLE: begin
            if (start) begin
               if (md_no_read(md_in)) begin
                  fin  = 1'b1;
                  f_ea = (md_in == MD_IMM) ? pc_in : '0;
               end else begin
                  st_d = ST_OPL;
               end
            end
         end
         ST_OPL: begin
            case (md_q)
               MD_ZPG: begin fin = 1'b1; f_ea = {{HW{1'b0}}, mem_rdata}; end
               MD_ZPX: begin fin = 1'b1; f_ea = {{HW{1'b0}}, mem_rdata + x_q}; end
               MD_ZPY: begin fin = 1'b1; f_ea = {{HW{1'b0}}, mem_rdata + y_q}; end
               MD_REL: begin
                  fin   = 1'b1;
                  f_ea  = br_target;
                  f_pc  = br_cross;
                  f_pen = br_pen;
               end
               MD_IDX, MD_IDY: st_d = ST_PTL;
               default:        st_d = ST_OPH;
            endcase
         end
         ST_OPH: begin
            case (md_q)
               MD_ABS: begin fin = 1'b1; f_ea = {mem_rdata, b0_q}; end
               MD_ABX, MD_ABY: begin
                  fin  = 1'b1;
                  f_ea = ix_sum;
                  f_pc = ix_cross;
               end
               default: st_d = ST_PTL;
            endcase
         end
         ST_PTL: st_d = ST_PTH;
         ST_PTH: begin
            fin = 1'b1;
            if (md_q == MD_IDY) begin
               f_ea = ix_sum;
               f_pc = ix_cross;
            end else begin
               f_ea = {mem_rdata, pl_q};
            end
         end
         default: st_d = ST_IDLE;
      endcase
      if (fin) st_d = ST_IDLE;
   end

   // ---- state ----
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         md_q <= MD_IMPL;
         pc_q <= '0;
         x_q  <= '0;
         y_q  <= '0;
         tk_q <= 1'b0;
         b0_q <= '0;
         b1_q <= '0;
         pl_q <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            md_q <= md_in;
            pc_q <= pc_in;
            x_q  <= x_in;
            y_q  <= y_in;
            tk_q <= taken;
         end
         if (st_q == ST_OPL) b0_q <= mem_rdata;
         if (st_q == ST_OPH) b1_q <= mem_rdata;
         if (st_q == ST_PTL) pl_q <= mem_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         ea_q    <= '0;
         ea_pc_q <= 1'b0;
         len_q   <= 2'd0;
         pen_q   <= 2'd0;
      end else begin
         done_q <= fin;
         if (accept) begin
            ea_pc_q <= 1'b0;
            pen_q   <= 2'd0;
            len_q   <= md_len(md_in);
         end
         if (fin) begin
            ea_q    <= f_ea;
            ea_pc_q <= f_pc;
            pen_q   <= f_pen;
         end
      end
   end

   assign busy       = (st_q != ST_IDLE);
   assign done       = done_q;
   assign ea         = ea_q;
   assign page_cross = ea_pc_q;
   assign op_len     = len_q;
   assign penalty    = pen_q;

endmodule

// File: rtl/addr_resolver_checker.sv
module addr_resolver_checker #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [3:0]    mode,
   input logic          busy,
   input logic          done,
   input logic          mem_req,
   input logic [AW-1:0] ea,
   input logic          page_cross,
   input logic [1:0]    op_len,
   input logic [1:0]    penalty
);
   logic [3:0] lmode;
   logic [1:0] exp_len;
   logic       acc;

   assign acc = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lmode <= 4'd0;
      else if (acc) lmode <= mode;
   end

   always_comb begin
      if (lmode == 4'd0 || lmode == 4'd1 || lmode > 4'd12) exp_len = 2'd0;
      else if (lmode >= 4'd7 && lmode <= 4'd10)            exp_len = 2'd2;
      else                                                 exp_len = 2'd1;
   end

   assert_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (mode == 4'd0 || mode == 4'd1 || mode > 4'd12))
      |=> (done && !mem_req && ea == '0 && op_len == 2'd0));

   assert_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (op_len == exp_len));

   assert_zp_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (lmode == 4'd3 || lmode == 4'd4 || lmode == 4'd5))
      |-> (ea[AW-1:DW] == '0));

   assert_pen_only_rel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && lmode != 4'd6) |-> (penalty == 2'd0));

   assert_pen_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (penalty != 2'd3));

   assert_pc_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !page_cross);

   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !acc && !busy) |=> $stable(ea));

endmodule

bind addr_resolver addr_resolver_checker #(.AW(AW), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .mode       (mode),
   .busy       (busy),
   .done       (done),
   .mem_req    (mem_req),
   .ea         (ea),
   .page_cross (page_cross),
   .op_len     (op_len),
   .penalty    (penalty)
);

// File: tb/addr_resolver_tb_top.sv
module addr_resolver_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode_in = 4'd0;
   logic [15:0] pc_in = 16'd0;
   logic [7:0]  x_in = 8'd0, y_in = 8'd0;
   logic        taken = 1'b0;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata;
   logic        busy, done, page_cross;
   logic [15:0] ea;
   logic [1:0]  op_len, penalty;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [7:0]  salt = 8'h00;
   logic [15:0] ov_a [8];
   logic [7:0]  ov_d [8];
   logic        ov_v [8];

   always #5 clk = ~clk;

   addr_resolver dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_in), .pc_in(pc_in),
      .x_in(x_in), .y_in(y_in), .taken(taken), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy), .done(done),
      .ea(ea), .page_cross(page_cross), .op_len(op_len), .penalty(penalty)
   );

   function automatic logic [7:0] memfn(input logic [15:0] a);
      logic [7:0] v;
      v = (a[7:0] * 8'd7) ^ (a[15:8] * 8'd13) ^ salt;
      for (int i = 0; i < 8; i++)
         if (ov_v[i] && ov_a[i] == a) v = ov_d[i];
      return v;
   endfunction

   always_comb mem_rdata = memfn(mem_addr);

   task automatic clear_ov();
      for (int i = 0; i < 8; i++) begin
         ov_v[i] = 1'b0; ov_a[i] = 16'd0; ov_d[i] = 8'd0;
      end
   endtask

   task automatic set_ov(input int i, input logic [15:0] a, input logic [7:0] d);
      ov_a[i] = a; ov_d[i] = d; ov_v[i] = 1'b1;
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic string ea_tag(input logic [3:0] m);
      case (m)
         4'd2:                 return "R4";
         4'd3, 4'd4, 4'd5:     return "R5";
         4'd6:                 return "R6";
         4'd7, 4'd8, 4'd9:     return "R8";
         4'd10:                return "R9";
         4'd11:                return "R10";
         4'd12:                return "R11";
         default:              return "R2";
      endcase
   endfunction

   // independent reference model
   task automatic model(input logic [3:0] m, input logic [15:0] pc,
                        input logic [7:0] x, input logic [7:0] y, input logic tk,
                        output logic [15:0] e, output logic pcx,
                        output logic [1:0] len, output logic [1:0] pen,
                        output int nrd);
      logic [7:0]  b, lo, hi, z;
      logic [15:0] nxt, base, p;
      e = 16'd0; pcx = 1'b0; pen = 2'd0; nrd = 0; len = 2'd1;
      b = memfn(pc);
      case (m)
         4'd2: e = pc;
         4'd3: begin e = {8'd0, b}; nrd = 1; end
         4'd4: begin z = b + x; e = {8'd0, z}; nrd = 1; end
         4'd5: begin z = b + y; e = {8'd0, z}; nrd = 1; end
         4'd6: begin
            nxt = pc + 16'd1;
            e   = nxt + {{8{b[7]}}, b};
            pcx = e[15:8] != nxt[15:8];
            pen = tk ? (pcx ? 2'd2 : 2'd1) : 2'd0;
            nrd = 1;
         end
         4'd7, 4'd8, 4'd9: begin
            base = {memfn(pc + 16'd1), b};
            nrd  = 2; len = 2'd2;
            if (m == 4'd7) e = base;
            else begin
               e   = base + {8'd0, (m == 4'd8) ? x : y};
               pcx = e[15:8] != base[15:8];
            end
         end
         4'd10: begin
            p  = {memfn(pc + 16'd1), b};
            lo = memfn(p);
            hi = memfn({p[15:8], p[7:0] + 8'd1});
            e  = {hi, lo}; nrd = 4; len = 2'd2;
         end
         4'd11: begin
            z = b + x;
            lo = memfn({8'd0, z});
            z = z + 8'd1;
            hi = memfn({8'd0, z});
            e = {hi, lo}; nrd = 3;
         end
         4'd12: begin
            lo = memfn({8'd0, b});
            z = b + 8'd1;
            hi = memfn({8'd0, z});
            base = {hi, lo};
            e = base + {8'd0, y};
            pcx = e[15:8] != base[15:8];
            nrd = 3;
         end
         default: len = 2'd0;
      endcase
   endtask

   task automatic run_op(input logic [3:0] m, input logic [15:0] pc,
                         input logic [7:0] x, input logic [7:0] y,
                         input logic tk, input bit poke);
      logic [15:0] e_ea; logic e_pc; logic [1:0] e_len, e_pen; int e_nrd;
      int cyc, rd;
      string tag;
      model(m, pc, x, y, tk, e_ea, e_pc, e_len, e_pen, e_nrd);
      tag = poke ? "R13" : ea_tag(m);
      @(negedge clk);
      mode_in = m; pc_in = pc; x_in = x; y_in = y; taken = tk; start = 1'b1;
      cyc = 0; rd = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (cyc == 1) begin
            start = poke && (e_nrd >= 2);
            if (start) begin mode_in = 4'd0; pc_in = ~pc; x_in = ~x; y_in = ~y; end
            if (e_nrd >= 1) begin
               chk("R12", "page_cross cleared at start", {31'd0, page_cross}, 32'd0);
            end
         end
         if (cyc == 2) start = 1'b0;
         if (done) break;
         if (mem_req) rd++;
         if (cyc > 12) break;
      end
      start = 1'b0;
      chk("R3", "done latency", cyc, e_nrd + 1);
      chk("R3", "read cycles", rd, e_nrd);
      chk("R3", "op_len", {30'd0, op_len}, {30'd0, e_len});
      chk(tag, "ea", {16'd0, ea}, {16'd0, e_ea});
      chk(tag, "page_cross", {31'd0, page_cross}, {31'd0, e_pc});
      chk("R7", "penalty", {30'd0, penalty}, {30'd0, e_pen});
   endtask

   task automatic check_hold();
      logic [15:0] e0; logic p0;
      e0 = ea; p0 = page_cross;
      repeat (2) @(negedge clk);
      chk("R12", "ea held", {16'd0, ea}, {16'd0, e0});
      chk("R12", "page_cross held", {31'd0, page_cross}, {31'd0, p0});
      chk("R12", "done single pulse", {31'd0, done}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      clear_ov();
      void'($urandom(32'h5eed_0a11));
      repeat (3) @(negedge clk);
      chk("R1", "busy", {31'd0, busy}, 32'd0);
      chk("R1", "done", {31'd0, done}, 32'd0);
      chk("R1", "mem_req", {31'd0, mem_req}, 32'd0);
      chk("R1", "outputs", {ea, 11'd0, page_cross, op_len, penalty}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: implied, accumulator, unused code
      run_op(4'd0, 16'h1234, 8'h11, 8'h22, 1'b0, 0);
      run_op(4'd1, 16'hABCD, 8'h11, 8'h22, 1'b0, 0);
      run_op(4'd14, 16'h8000, 8'h11, 8'h22, 1'b1, 0);
      // R4 immediate
      run_op(4'd2, 16'hC0DE, 8'h00, 8'h00, 1'b0, 0);
      // R5 zero page X wrap
      clear_ov(); set_ov(0, 16'h0200, 8'hF0);
      run_op(4'd4, 16'h0200, 8'h20, 8'h00, 1'b0, 0);
      // R6/R7 backward branch across page, taken and not taken
      clear_ov(); set_ov(0, 16'h0400, 8'h80);
      run_op(4'd6, 16'h0400, 8'h00, 8'h00, 1'b1, 0);
      run_op(4'd6, 16'h0400, 8'h00, 8'h00, 1'b0, 0);
      // R7 same page taken
      clear_ov(); set_ov(0, 16'h0410, 8'h05);
      run_op(4'd6, 16'h0410, 8'h00, 8'h00, 1'b1, 0);
      // R8 absolute X crossing, then hold check
      clear_ov(); set_ov(0, 16'h0600, 8'hF0); set_ov(1, 16'h0601, 8'h12);
      run_op(4'd8, 16'h0600, 8'h20, 8'h00, 1'b0, 0);
      check_hold();
      // R9 indirect page wrap quirk
      clear_ov(); set_ov(0, 16'h0300, 8'hFF); set_ov(1, 16'h0301, 8'h02);
      set_ov(2, 16'h02FF, 8'h34); set_ov(3, 16'h0200, 8'h12);
      run_op(4'd10, 16'h0300, 8'h00, 8'h00, 1'b0, 0);
      chk("R9", "wrapped pointer result", {16'd0, ea}, 32'h1234);
      // R10 indexed-indirect pointer wraps in zero page
      clear_ov(); set_ov(0, 16'h0700, 8'hFE); set_ov(1, 16'h00FF, 8'h78);
      set_ov(2, 16'h0000, 8'h56);
      run_op(4'd11, 16'h0700, 8'h01, 8'h00, 1'b0, 0);
      chk("R10", "zero page pointer", {16'd0, ea}, 32'h5678);
      // R11 indirect-indexed with crossing, pointer at FF wraps
      clear_ov(); set_ov(0, 16'h0800, 8'hFF); set_ov(1, 16'h00FF, 8'h80);
      set_ov(2, 16'h0000, 8'h12);
      run_op(4'd12, 16'h0800, 8'h00, 8'h90, 1'b0, 0);
      chk("R11", "indexed pointer", {15'd0, page_cross, ea}, 32'h1_1310);
      // R13 start ignored while busy
      clear_ov();
      run_op(4'd10, 16'h1F00, 8'h00, 8'h00, 1'b0, 1);
      run_op(4'd7, 16'h2FFF, 8'h00, 8'h00, 1'b0, 1);

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [3:0] m;
         salt = 8'($urandom);
         m = 4'($urandom_range(0, 15));
         run_op(m, 16'($urandom), 8'($urandom), 8'($urandom),
                1'($urandom), ($urandom_range(0, 7) == 0));
      end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule